// File: doc/BRIEF.md
# Cycle-Steal and Interrupt Multiplexer

Several device adapters share one host channel that offers a single cycle-steal level and a small set of interrupt levels. This block merges the devices' cycle-steal requests into one request toward the host. When the host raises its cycle-steal level 1 response, the block passes it to exactly one device, the current owner, and keeps it hidden from every other device. Requests from devices that lose arbitration stay pending. They are served in fixed priority order once the owner lets go. Index 0 has the highest priority, and an owner is never preempted.

Interrupts work the same way, one picker per level. Each level's host request is the OR of the devices raising that level. The host's acknowledge for a level is steered to the highest-priority device requesting that level, and the next device is served after it drops its request. Outbound I/O instruction traffic does not pass through this block.

The cycle-steal arbiter is a two-state machine. The states are `ARB_IDLE` (no owner) and `ARB_OWNED` (one owner). Its transitions are:
- claim: `ARB_IDLE`→`ARB_OWNED` when any request is present.
- hold: `ARB_OWNED`→`ARB_OWNED` with the same owner while the owner keeps requesting.
- handoff: `ARB_OWNED`→`ARB_OWNED` with a new owner when the owner drops its request and another request is pending.
- release: `ARB_OWNED`→`ARB_IDLE` when the owner drops its request and nothing else is pending.

The reset is synchronous and active high.

Top module: `cs_irq_mux`

## Requirements
- R1: `host_cs_req` is high in the same cycle as any bit of `dev_cs_req`, and low when all bits are low.
- R2: At most one bit of `dev_cs_grant` is high in any cycle. A high bit is always the bit at `owner_idx`, and only while `owner_vld` is high.
- R3: In `ARB_IDLE`, if any request is present at a clock edge, then after that edge `owner_vld` is 1 and `owner_idx` is the lowest requesting index (claim).
- R4: While the owner's request stays high, `owner_idx` does not change, even when a lower index starts requesting (hold, no preemption).
- R5: At the first edge where the owner's request is low, the owner becomes the lowest-index device still requesting (handoff). If no device is requesting, `owner_vld` becomes 0 (release).
- R6: After each edge, `dev_cs_grant` equals a one-hot vector at the new owner if `host_cs_lvl1` was high at that edge and an owner exists, and all zeros otherwise. Non-owners never see the grant.
- R7: A device whose request stays high while others own the channel is not dropped. It becomes the owner when the devices ahead of it in priority have released.
- R8: `host_irq[l]` is the OR, in the same cycle, of the interrupt request bits of level l. Device d on level l uses bit l*N_DEV+d.
- R9: After each edge, on each level l, at most one bit of `dev_irq_ack` is high. It is the lowest requesting device on that level at that edge, and only if `host_irq_ack[l]` was high at that edge.
- R10: A clock edge with `rst` high clears `owner_vld`, `dev_cs_grant` and `dev_irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_cs_req | input | N_DEV | Cycle-steal request per device |
| host_cs_req | output | 1 | Merged cycle-steal request to host |
| host_cs_lvl1 | input | 1 | Host cycle-steal level 1 response |
| dev_cs_grant | output | N_DEV | Gated level 1 seen by each device (registered) |
| owner_vld | output | 1 | An owner is selected |
| owner_idx | output | $clog2(N_DEV) | Index of the current owner |
| dev_irq | input | N_LVL*N_DEV | Interrupt requests, bit l*N_DEV+d |
| host_irq | output | N_LVL | Merged interrupt request per level |
| host_irq_ack | input | N_LVL | Host acknowledge per level |
| dev_irq_ack | output | N_LVL*N_DEV | Gated acknowledge per device and level (registered) |

## Verification
The hardest situation to reach is a hold in which a higher-priority device starts requesting while a lower-priority owner is being granted. The bench must then show that the newcomer stays masked, and that at the owner's release the grant hands off to it in the same edge rather than passing through idle. Scripted steps keep several request lines high across many cycles, so arrival, hold and handoff line up on chosen edges. A long pseudo-random stream follows, with request lines that change only occasionally, so that holds and chained handoffs occur often. A reference model in the driver predicts every registered output.

// File: rtl/cim_pkg.sv
package cim_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;
endpackage

// File: rtl/cim_prio_pick.sv
// Fixed-priority picker: lowest set index wins.
module cim_prio_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  win_oh,
    output logic [IW-1:0] win_idx,
    output logic          any
);
    always_comb begin
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) win_idx = IW'(i);
        end
        any    = |req;
        win_oh = '0;
        if (any) win_oh[win_idx] = 1'b1;
    end
endmodule

// File: rtl/cim_cs_arb.sv
// Cycle-steal ownership machine with registered, owner-masked level 1.
module cim_cs_arb
    import cim_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          lvl1,
    output logic [N-1:0]  grant,
    output logic          owner_vld,
    output logic [IW-1:0] owner_idx
);
    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [N-1:0]  grant_q;
    logic [N-1:0]  pick_oh;
    logic [IW-1:0] pick_idx;
    logic          pick_any;

    cim_prio_pick #(.N(N)) u_pick (
        .req     (req),
        .win_oh  (pick_oh),
        .win_idx (pick_idx),
        .any     (pick_any)
    );

    // Next-state: claim, hold, handoff, release.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (pick_any) begin
                    state_d = ARB_OWNED;
                    owner_d = pick_idx;
                end
            end
            ARB_OWNED: begin
                if (!req[owner_q]) begin
                    if (pick_any) begin
                        owner_d = pick_idx;
                    end else begin
                        state_d = ARB_IDLE;
                    end
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Output register: level 1 reaches only the next owner.
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else if (state_d == ARB_OWNED && lvl1) begin
            grant_q <= N'(1) << owner_d;
        end else begin
            grant_q <= '0;
        end
    end

    assign grant     = grant_q;
    assign owner_vld = (state_q == ARB_OWNED);
    assign owner_idx = owner_q;
endmodule

// File: rtl/cim_irq_gate.sv
// One interrupt level: merged request, acknowledge steered to top requester.
module cim_irq_gate #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         host_ack,
    output logic         host_req,
    output logic [N-1:0] dev_ack
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  pick_oh;
    logic [IW-1:0] pick_idx;
    logic          pick_any;
    logic [N-1:0]  ack_q;

    cim_prio_pick #(.N(N)) u_pick (
        .req     (req),
        .win_oh  (pick_oh),
        .win_idx (pick_idx),
        .any     (pick_any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= '0;
        end else begin
            ack_q <= host_ack ? pick_oh : '0;
        end
    end

    assign host_req = pick_any;
    assign dev_ack  = ack_q;
endmodule

// File: rtl/cs_irq_mux.sv
module cs_irq_mux #(
    parameter int N_DEV = 4,
    parameter int N_LVL = 2,
    localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_DEV-1:0]       dev_cs_req,
    output logic                   host_cs_req,
    input  logic                   host_cs_lvl1,
    output logic [N_DEV-1:0]       dev_cs_grant,
    output logic                   owner_vld,
    output logic [IW-1:0]          owner_idx,
    input  logic [N_LVL*N_DEV-1:0] dev_irq,
    output logic [N_LVL-1:0]       host_irq,
    input  logic [N_LVL-1:0]       host_irq_ack,
    output logic [N_LVL*N_DEV-1:0] dev_irq_ack
);
    assign host_cs_req = |dev_cs_req;

    cim_cs_arb #(.N(N_DEV)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (dev_cs_req),
        .lvl1      (host_cs_lvl1),
        .grant     (dev_cs_grant),
        .owner_vld (owner_vld),
        .owner_idx (owner_idx)
    );

    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
        cim_irq_gate #(.N(N_DEV)) u_gate (
            .clk      (clk),
            .rst      (rst),
            .req      (dev_irq[l*N_DEV +: N_DEV]),
            .host_ack (host_irq_ack[l]),
            .host_req (host_irq[l]),
            .dev_ack  (dev_irq_ack[l*N_DEV +: N_DEV])
        );
    end
endmodule

// File: rtl/cs_irq_mux_chk.sv
module cs_irq_mux_chk #(
    parameter int N_DEV = 4,
    parameter int N_LVL = 2,
    localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_DEV-1:0]       dev_cs_req,
    input logic                   host_cs_lvl1,
    input logic [N_DEV-1:0]       dev_cs_grant,
    input logic                   owner_vld,
    input logic [IW-1:0]          owner_idx,
    input logic [N_LVL*N_DEV-1:0] dev_irq_ack
);
    assert_grant_single_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_cs_grant));

    assert_grant_owner_R2: assert property (@(posedge clk) disable iff (rst)
        (|dev_cs_grant) |-> (owner_vld && dev_cs_grant[owner_idx]));

    assert_claim_top_R3: assert property (@(posedge clk) disable iff (rst)
        (!owner_vld && dev_cs_req[0]) |=> (owner_vld && owner_idx == '0));

    assert_no_preempt_R4: assert property (@(posedge clk) disable iff (rst)
        (owner_vld && dev_cs_req[owner_idx]) |=> (owner_vld && owner_idx == $past(owner_idx)));

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (owner_vld && dev_cs_req == '0) |=> !owner_vld);

    assert_mask_low_R6: assert property (@(posedge clk) disable iff (rst)
        !host_cs_lvl1 |=> (dev_cs_grant == '0));

    for (genvar l = 0; l < N_LVL; l++) begin : g_ack
        assert_ack_single_R9: assert property (@(posedge clk) disable iff (rst)
            $onehot0(dev_irq_ack[l*N_DEV +: N_DEV]));
    end

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!owner_vld && dev_cs_grant == '0 && dev_irq_ack == '0));
endmodule

bind cs_irq_mux cs_irq_mux_chk #(.N_DEV(N_DEV), .N_LVL(N_LVL)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dev_cs_req   (dev_cs_req),
    .host_cs_lvl1 (host_cs_lvl1),
    .dev_cs_grant (dev_cs_grant),
    .owner_vld    (owner_vld),
    .owner_idx    (owner_idx),
    .dev_irq_ack  (dev_irq_ack)
);

// File: tb/cs_irq_mux_bench.sv
module cs_irq_mux_bench;
    localparam int N  = 4;
    localparam int L  = 2;
    localparam int IW = $clog2(N);

    typedef struct {
        logic          vld;
        logic [IW-1:0] idx;
        logic [N-1:0]  grant;
        logic [N*L-1:0] ack;
        string         tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   dev_cs_req = '0;
    logic           host_cs_req;
    logic           host_cs_lvl1 = 1'b0;
    logic [N-1:0]   dev_cs_grant;
    logic           owner_vld;
    logic [IW-1:0]  owner_idx;
    logic [N*L-1:0] dev_irq = '0;
    logic [L-1:0]   host_irq;
    logic [L-1:0]   host_irq_ack = '0;
    logic [N*L-1:0] dev_irq_ack;

    int checks   = 0;
    int failures = 0;
    exp_t sb[$];

    // Reference model state.
    logic          m_vld = 1'b0;
    logic [IW-1:0] m_own = '0;

    always #10 clk = ~clk;

    cs_irq_mux u_cs_irq_mux (
        .clk(clk), .rst(rst),
        .dev_cs_req(dev_cs_req), .host_cs_req(host_cs_req),
        .host_cs_lvl1(host_cs_lvl1), .dev_cs_grant(dev_cs_grant),
        .owner_vld(owner_vld), .owner_idx(owner_idx),
        .dev_irq(dev_irq), .host_irq(host_irq),
        .host_irq_ack(host_irq_ack), .dev_irq_ack(dev_irq_ack)
    );

    function automatic logic [IW:0] lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return {1'b1, IW'(i)};
        return '0;
    endfunction

    task automatic step(input logic r, input logic [N-1:0] req, input logic l1,
                        input logic [N*L-1:0] irq, input logic [L-1:0] iack,
                        input string tag);
        exp_t e;
        logic [IW:0] p;
        @(negedge clk);
        rst = r; dev_cs_req = req; host_cs_lvl1 = l1;
        dev_irq = irq; host_irq_ack = iack;
        #1;
        checks++;
        if (host_cs_req !== (|req)) begin
            failures++;
            $display("FAIL R1 host_cs_req act=%b exp=%b", host_cs_req, |req);
        end
        for (int l = 0; l < L; l++) begin
            checks++;
            if (host_irq[l] !== (|irq[l*N +: N])) begin
                failures++;
                $display("FAIL R8 host_irq[%0d] act=%b exp=%b", l, host_irq[l], |irq[l*N +: N]);
            end
        end
        e.ack = '0;
        if (r) begin
            m_vld = 1'b0; m_own = '0; e.grant = '0;
        end else begin
            if (!m_vld || !req[m_own]) begin
                p = lowest(req);
                m_vld = p[IW];
                if (p[IW]) m_own = p[IW-1:0];
            end
            e.grant = (m_vld && l1) ? (N'(1) << m_own) : '0;
            for (int l = 0; l < L; l++) begin
                p = lowest(irq[l*N +: N]);
                if (iack[l] && p[IW]) e.ack[l*N + int'(p[IW-1:0])] = 1'b1;
            end
        end
        e.vld = m_vld; e.idx = m_own; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares registered outputs after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (owner_vld !== e.vld || (e.vld && owner_idx !== e.idx)) begin
                    failures++;
                    $display("FAIL %s owner act=%b/%0d exp=%b/%0d", e.tag, owner_vld, owner_idx, e.vld, e.idx);
                end
                checks++;
                if (dev_cs_grant !== e.grant) begin
                    failures++;
                    $display("FAIL %s grant act=%b exp=%b", e.tag, dev_cs_grant, e.grant);
                end
                checks++;
                if (dev_irq_ack !== e.ack) begin
                    failures++;
                    $display("FAIL %s irq_ack act=%b exp=%b", e.tag, dev_irq_ack, e.ack);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] rq;
        logic [N*L-1:0] iq;
        // R10 reset state
        step(1, '0, 0, '0, '0, "R10");
        step(1, 4'b1111, 1, '1, '1, "R10");
        step(0, '0, 1, '0, '0, "R3_idle");
        // R3 claim lowest requester, R6 level 1 masked while host low
        step(0, 4'b1010, 0, '0, '0, "R3");
        step(0, 4'b1010, 1, '0, '0, "R6");
        // R4 higher priority arrives: no preemption, newcomer masked
        step(0, 4'b1011, 1, '0, '0, "R4");
        step(0, 4'b1011, 1, '0, '0, "R4");
        // R5 handoff to device 0, then R7 pending device 3 served
        step(0, 4'b1001, 1, '0, '0, "R5");
        step(0, 4'b1000, 1, '0, '0, "R7");
        step(0, 4'b1000, 0, '0, '0, "R6");
        step(0, 4'b0000, 1, '0, '0, "R5_release");
        // R9 interrupt acknowledge steering, R8 merged requests
        step(0, '0, 0, 8'b1000_0110, 2'b01, "R9");
        step(0, '0, 0, 8'b1000_0110, 2'b11, "R9");
        step(0, '0, 0, 8'b1000_0100, 2'b11, "R9");
        step(0, '0, 0, 8'b1000_0100, 2'b00, "R9");
        // R10 reset while owning
        step(0, 4'b0100, 1, '0, '0, "R3");
        step(1, 4'b0100, 1, '0, '0, "R10");
        step(0, 4'b0100, 1, '0, '0, "R3");
        // Random stream with slowly changing requests
        rq = '0; iq = '0;
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 3) == 0) rq = N'($urandom);
            if ($urandom_range(0, 3) == 0) iq = (N*L)'($urandom);
            step(($urandom_range(0, 99) == 0), rq, 1'($urandom), iq, L'($urandom), "R2_R7_R9_rand");
        end
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule